// File: doc/BRIEF.md
# In-Bank Row Copy Command Sequencer

This block sits in a memory controller and copies one DRAM row onto another inside the same bank, without moving any data over the data bus. A client hands it a bank number, a source row and a destination row. The block first checks that both rows belong to the same subarray. A subarray is named by a parameterized group of the most significant row-address bits. If the rows are in different subarrays, the block refuses the request with an error response and sends nothing to the DRAM.

For an allowed request, the block drives a fixed command sequence onto the command port:
1. It opens the source row, which loads the whole row into the bank's sense amplifiers.
2. It sends a close command that shuts the source wordline without precharging, so the amplifiers keep the latched row.
3. It opens the destination row. The amplifiers then drive the latched row into that row.
4. It precharges the bank normally and reports completion.

The spacing between commands comes from three cycle-count inputs: row-active time, close-to-open gap and precharge time. A value of zero counts as one cycle. The block takes one request at a time through a valid/ready handshake.

Top module: `row_copy_seq`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and both `cmd_valid` and `rsp_valid` are 0.
- R2: When a request whose rows share a subarray is accepted on a clock edge, that same edge issues a one-cycle command with `cmd_op`=1 (open) for the source row, with `cmd_bank` set to the request bank.
- R3: The source close command (`cmd_op`=2, close without precharge, `cmd_row` = source) follows the source open by exactly `cfg_t_ras` cycles.
- R4: The destination open (`cmd_op`=1, `cmd_row` = destination) follows the close by exactly `cfg_t_gap` cycles. After it, the destination row holds the source row's former contents and the source row is unchanged.
- R5: A precharge (`cmd_op`=3, `cmd_row` = destination) follows the destination open by exactly `cfg_t_ras` cycles.
- R6: `rsp_valid` pulses for one cycle with `rsp_err`=0 exactly `cfg_t_rp` cycles after the precharge. `req_ready` is 1 in that same cycle.
- R7: A request whose source and destination differ in the top `SA_W` row bits gets `rsp_valid`=1 with `rsp_err`=1 in the cycle after acceptance, and no command is issued for it.
- R8: While a copy is in progress `req_ready` is 0 and `req_valid` is ignored: the copy issues exactly four commands and no extra response appears.
- R9: A timing input of 0 behaves as 1 cycle.
- R10: `cmd_valid` is high only for the four commands of a copy, and `cmd_op` uses only the codes 1, 2 and 3 while valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_bank | input | BANK_W | Target bank |
| req_src_row | input | ROW_W | Source row address |
| req_dst_row | input | ROW_W | Destination row address |
| cfg_t_ras | input | TW | Row-active time in cycles |
| cfg_t_gap | input | TW | Close-to-open gap in cycles |
| cfg_t_rp | input | TW | Precharge time in cycles |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_op | output | 2 | 1 open, 2 close keeping amplifiers, 3 precharge |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | 1 when the request was refused |

## Verification
A bad sequencer state shows at the command port within one timing window. It can show as a command in the wrong order, a command at the wrong spacing from its predecessor, or a missing precharge that leaves the next open silently reading amplifier contents. A wrong subarray decision shows in the cycle right after the handshake, as a command where an error was due or as an error where a command was due. The bench feeds the commands to a small bank model with sense-amplifier state. A sequence that is reordered or not closed correctly therefore also shows up as wrong destination data, and as an overwritten source row.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ACT   = 2'd1,
    OP_DEACT = 2'd2,
    OP_PRE   = 2'd3
  } cmd_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RAS_SRC,
    S_GAP,
    S_RAS_DST,
    S_RP
  } seq_state_e;
endpackage

// File: rtl/rcs_subarray_chk.sv
module rcs_subarray_chk #(
  parameter int ROW_W = 16,
  parameter int SA_W  = 6
) (
  input  logic [ROW_W-1:0] src_row,
  input  logic [ROW_W-1:0] dst_row,
  output logic             same_sa
);
  localparam int SA_LSB = ROW_W - SA_W;

  logic [SA_W-1:0] src_sa;
  logic [SA_W-1:0] dst_sa;

  assign src_sa  = src_row[ROW_W-1:SA_LSB];
  assign dst_sa  = dst_row[ROW_W-1:SA_LSB];
  assign same_sa = (src_sa == dst_sa);
endmodule

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? TW'(1) : load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign last = (cnt == TW'(1));

  AST_TMR_ZERO_CLAMP: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt != '0)); // R9
endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
  import rcs_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [ROW_W-1:0]  req_dst_row,
  input  logic              same_sa,
  input  logic [TW-1:0]     cfg_t_ras,
  input  logic [TW-1:0]     cfg_t_gap,
  input  logic [TW-1:0]     cfg_t_rp,
  input  logic              tmr_last,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              rsp_valid,
  output logic              rsp_err
);
  seq_state_e        state;
  cmd_op_e           op_q;
  logic [ROW_W-1:0]  src_q;
  logic [ROW_W-1:0]  dst_q;
  logic              accept;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_op    = op_q;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = cfg_t_ras;
    unique case (state)
      S_IDLE:    begin tmr_load = req_valid && same_sa; tmr_val = cfg_t_ras; end
      S_RAS_SRC: begin tmr_load = tmr_last;             tmr_val = cfg_t_gap; end
      S_GAP:     begin tmr_load = tmr_last;             tmr_val = cfg_t_ras; end
      S_RAS_DST: begin tmr_load = tmr_last;             tmr_val = cfg_t_rp;  end
      default:   begin tmr_load = 1'b0;                 tmr_val = cfg_t_ras; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_NOP;
      cmd_valid <= 1'b0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      op_q      <= OP_NOP;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            if (same_sa) begin
              cmd_valid <= 1'b1;
              op_q      <= OP_ACT;
              cmd_bank  <= req_bank;
              cmd_row   <= req_src_row;
              src_q     <= req_src_row;
              dst_q     <= req_dst_row;
              state     <= S_RAS_SRC;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end
          end
        end
        S_RAS_SRC: begin
          if (tmr_last) begin
            cmd_valid <= 1'b1;
            op_q      <= OP_DEACT;
            cmd_row   <= src_q;
            state     <= S_GAP;
          end
        end
        S_GAP: begin
          if (tmr_last) begin
            cmd_valid <= 1'b1;
            op_q      <= OP_ACT;
            cmd_row   <= dst_q;
            state     <= S_RAS_DST;
          end
        end
        S_RAS_DST: begin
          if (tmr_last) begin
            cmd_valid <= 1'b1;
            op_q      <= OP_PRE;
            cmd_row   <= dst_q;
            state     <= S_RP;
          end
        end
        S_RP: begin
          if (tmr_last) begin
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_OPENS_SRC: assert property (@(posedge clk) disable iff (rst)
    (accept && same_sa) |=> (cmd_valid && cmd_op == 2'd1 && cmd_row == $past(req_src_row))); // R2
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && !same_sa) |=> (rsp_valid && rsp_err && !cmd_valid)); // R7
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready); // R8
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> (req_ready && !cmd_valid)); // R6
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != 2'd0)); // R10
endmodule

// File: rtl/row_copy_seq.sv
module row_copy_seq #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int SA_W   = 6,
  parameter int TW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [ROW_W-1:0]  req_dst_row,
  input  logic [TW-1:0]     cfg_t_ras,
  input  logic [TW-1:0]     cfg_t_gap,
  input  logic [TW-1:0]     cfg_t_rp,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              rsp_valid,
  output logic              rsp_err
);
  logic          same_sa;
  logic          tmr_load;
  logic          tmr_last;
  logic [TW-1:0] tmr_val;

  rcs_subarray_chk #(.ROW_W(ROW_W), .SA_W(SA_W)) u_chk (
    .src_row (req_src_row),
    .dst_row (req_dst_row),
    .same_sa (same_sa)
  );

  rcs_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  rcs_fsm #(.BANK_W(BANK_W), .ROW_W(ROW_W), .TW(TW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_bank    (req_bank),
    .req_src_row (req_src_row),
    .req_dst_row (req_dst_row),
    .same_sa     (same_sa),
    .cfg_t_ras   (cfg_t_ras),
    .cfg_t_gap   (cfg_t_gap),
    .cfg_t_rp    (cfg_t_rp),
    .tmr_last    (tmr_last),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_row     (cmd_row),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err)
  );
endmodule

// File: tb/sim_row_copy_seq.sv
module sim_row_copy_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 8;
  localparam int SA_W   = 3;
  localparam int TW     = 6;
  localparam int NBANK  = 1 << BANK_W;
  localparam int NROW   = 1 << ROW_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_src_row = '0;
  logic [ROW_W-1:0]  req_dst_row = '0;
  logic [TW-1:0]     cfg_t_ras = TW'(3);
  logic [TW-1:0]     cfg_t_gap = TW'(2);
  logic [TW-1:0]     cfg_t_rp  = TW'(3);
  logic              cmd_valid;
  logic [1:0]        cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;
  logic              rsp_valid;
  logic              rsp_err;

  row_copy_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .SA_W(SA_W), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_src_row(req_src_row), .req_dst_row(req_dst_row),
    .cfg_t_ras(cfg_t_ras), .cfg_t_gap(cfg_t_gap), .cfg_t_rp(cfg_t_rp),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done_all = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bank model: 0 closed, 1 row open, 2 amplifiers latched with wordline closed
  logic [15:0] mem [NBANK][NROW];
  logic [15:0] amp [NBANK];
  int          bst [NBANK];

  int          n_cmd;
  int          log_op  [8];
  int          log_row [8];
  int          log_cyc [8];
  int          log_bank[8];
  int          n_rsp;
  int          rsp_cyc;
  int          rsp_e;

  function automatic logic [15:0] pat(int b, int r);
    return 16'(16'hA5C3 ^ (b << 12) ^ (r * 37));
  endfunction

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (n_cmd < 8) begin
        log_op[n_cmd] = int'(cmd_op); log_row[n_cmd] = int'(cmd_row);
        log_cyc[n_cmd] = cyc; log_bank[n_cmd] = int'(cmd_bank);
      end
      n_cmd = n_cmd + 1;
      case (cmd_op)
        2'd1: begin
          if (bst[cmd_bank] == 2) mem[cmd_bank][cmd_row] = amp[cmd_bank];
          else amp[cmd_bank] = mem[cmd_bank][cmd_row];
          bst[cmd_bank] = 1;
        end
        2'd2: bst[cmd_bank] = 2;
        2'd3: bst[cmd_bank] = 0;
        default: ;
      endcase
    end
    if (!rst && rsp_valid) begin
      n_rsp = n_rsp + 1; rsp_cyc = cyc; rsp_e = int'(rsp_err);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_cmd = 0; n_rsp = 0; rsp_cyc = -1; rsp_e = -1;
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // issue one request; intrude=1 keeps req_valid high with another request while busy
  task automatic run_copy(int b, int src, int dst, int tras, int tgap, int trp, bit intrude);
    int a;
    int e1;
    int e2;
    int e3;
    int e4;
    bit rdy_low;
    @(negedge clk);
    clear_log();
    cfg_t_ras = TW'(tras); cfg_t_gap = TW'(tgap); cfg_t_rp = TW'(trp);
    req_bank = BANK_W'(b); req_src_row = ROW_W'(src); req_dst_row = ROW_W'(dst);
    check(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    a = cyc;
    rdy_low = 1'b1;
    if (intrude) begin
      req_src_row = ROW_W'(src ^ 1); req_dst_row = ROW_W'(dst ^ 2);
      for (int i = 0; i < 3; i++) begin
        if (req_ready) rdy_low = 1'b0;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    for (int i = 0; i < 200 && n_rsp == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    e1 = a + eff(tras); e2 = e1 + eff(tgap); e3 = e2 + eff(tras); e4 = e3 + eff(trp);
    check(n_cmd == 4, "R10 four commands per copy", n_cmd, 4);
    check(log_op[0] == 1 && log_row[0] == src && log_cyc[0] == a && log_bank[0] == b,
          "R2 source open", log_cyc[0] - a, 0);
    check(log_op[1] == 2 && log_row[1] == src && log_cyc[1] == e1,
          "R3 close after row-active time", log_cyc[1] - a, e1 - a);
    check(log_op[2] == 1 && log_row[2] == dst && log_cyc[2] == e2,
          "R4 destination open after gap", log_cyc[2] - a, e2 - a);
    check(log_op[3] == 3 && log_row[3] == dst && log_cyc[3] == e3,
          "R5 precharge after row-active time", log_cyc[3] - a, e3 - a);
    check(n_rsp == 1 && rsp_e == 0 && rsp_cyc == e4,
          "R6 completion response", rsp_cyc - a, e4 - a);
    check(mem[b][dst] == pat(b, src), "R4 destination holds source data",
          int'(mem[b][dst]), int'(pat(b, src)));
    check(mem[b][src] == pat(b, src), "R4 source row unchanged",
          int'(mem[b][src]), int'(pat(b, src)));
    if (intrude) check(rdy_low, "R8 ready low while busy", int'(rdy_low), 1);
  endtask

  task automatic run_reject(int b, int src, int dst);
    @(negedge clk);
    clear_log();
    req_bank = BANK_W'(b); req_src_row = ROW_W'(src); req_dst_row = ROW_W'(dst);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_err, "R7 error response next cycle", int'(rsp_err), 1);
    repeat (8) @(negedge clk);
    check(n_cmd == 0, "R7 no command on refusal", n_cmd, 0);
    check(n_rsp == 1, "R7 single response", n_rsp, 1);
    check(mem[b][dst] == pat(b, dst), "R7 destination untouched",
          int'(mem[b][dst]), int'(pat(b, dst)));
  endtask

  task automatic test_reset();
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R1 no command after reset", int'(cmd_valid), 0);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
  endtask

  always @(posedge clk) begin
    if (!done_all && cyc > 100000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NBANK; b++) begin
      amp[b] = '0; bst[b] = 0;
      for (int r = 0; r < NROW; r++) mem[b][r] = pat(b, r);
    end
    clear_log();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_copy(1, 8'h12, 8'h1A, 3, 2, 4, 1'b0);
    run_copy(2, 8'hE5, 8'hE0, 5, 1, 2, 1'b0);
    run_reject(3, 8'h20, 8'h40);
    run_copy(0, 8'h61, 8'h7F, 0, 0, 0, 1'b0); // R9 zero timing values act as one cycle
    run_copy(3, 8'h83, 8'h9C, 2, 3, 1, 1'b1);
    run_reject(0, 8'h05, 8'hF5);
    done_all = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule